// File: doc/BRIEF.md
# Bit-Serial EEPROM With Host Register Port

This block models a small serial EEPROM of 128 eight-bit words that a processor drives one bit at a time. The host never sees a serial bus: it writes a 32-bit register whose top byte lane carries the chip select, serial clock and data-in lines, and it reads a 32-bit register that returns the data-out line and a ready flag. Software toggles the clock line through successive register writes. The model decodes each command from the bit stream, shifts in addresses and data, shifts read data back out, and tracks a write-protect lock.

Commands start right after chip select is asserted. Read and write start with a 6-bit opcode. Erase-all, lock and unlock are 13-bit codes. Addresses and data travel most significant bit first. Programming completes at once, so the ready flag is always set. Contents do not survive a reset.

Top module: `eep_hostreg_top`

## Requirements
- R1: A host write updates the serial lines only when `wr_en` and `wr_be[3]` are both high. The lines are: bit 24 is data-in, bit 26 is the serial clock, and bit 25 high deasserts chip select. Writes without `wr_be[3]`, and every other bit of the word, have no effect.
- R2: The read register `rd_data` has bit 9 always 1 (ready) and bit 8 equal to serial data-out. All other bits read 0.
- R3: One serial bit is taken for each host write that moves the clock line from 0 to 1 while that same write keeps chip select asserted. A write that leaves the clock high adds no bit. The effect of a bit appears in `rd_data` two clock cycles after the write is presented.
- R4: The bits 0,1,1,0,0,0 (first bit on the left) followed by 7 address bits start a read. On the edge that carries the last address bit, data-out shows bit 7 of the addressed word. Each following rising edge shows the next lower bit. The eighth following edge drops data-out to 0, and the device then ignores bits until chip select is deasserted.
- R5: The bits 0,1,0,1,0,0, then 7 address bits, then 8 data bits, store the data word at the address when the device is unlocked.
- R6: The 13-bit code 0100100000000 sets every word to 0xFF when the device is unlocked.
- R7: The 13-bit code 0100110000000 clears the lock. The 13-bit code 0100000000000 sets it.
- R8: The lock is set by reset. While the lock is set, write and erase-all commands leave the array unchanged.
- R9: Deasserting chip select discards any partial command and returns data-out to 0.
- R10: A 13-bit sequence that matches no command is ignored, along with every bit after it, until chip select is deasserted.
- R11: After reset every word reads 0xFF, chip select is deasserted, the clock line is low and `rd_data` is 0x0000_0200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the line register |
| wr_data | input | 32 | Host write word carrying the serial lines |
| wr_be | input | 4 | Host byte-lane enables |
| rd_data | output | 32 | Host read word with data-out and ready |

## Verification
The assertions assume the host changes the serial clock only through writes with lane 3 enabled. They also assume that a strobe reaching the decoder always finds chip select asserted, and that lock and unlock requests never coincide. The stimulus keeps to this by driving every serial bit as two separate host writes: one with the clock low and one with the clock high, each followed by an idle cycle. Chip select is released only by a dedicated write. Deliberate departures are limited to writes on other lanes, writes to undefined bits and repeated clock-high writes, and these are exactly the cases the requirements say must change nothing.

// File: rtl/eep_pkg.sv
// Shared constants and types for the bit-serial EEPROM model.
// Assumes the three serial lines sit in one byte lane of the host word.
package eep_pkg;

    typedef enum logic [2:0] {
        PH_CMD   = 3'd0,
        PH_RADDR = 3'd1,
        PH_RDATA = 3'd2,
        PH_WADDR = 3'd3,
        PH_WDATA = 3'd4,
        PH_HALT  = 3'd5
    } phase_t;

    localparam int OP_SHORT = 6;
    localparam int OP_LONG  = 13;

    localparam logic [OP_SHORT-1:0] PAT_READ   = 6'b011000;
    localparam logic [OP_SHORT-1:0] PAT_WRITE  = 6'b010100;
    localparam logic [OP_LONG-1:0]  PAT_ERASE  = 13'b0100100000000;
    localparam logic [OP_LONG-1:0]  PAT_LOCK   = 13'b0100000000000;
    localparam logic [OP_LONG-1:0]  PAT_UNLOCK = 13'b0100110000000;

    localparam int HB_DI  = 24;
    localparam int HB_CSN = 25;
    localparam int HB_SCK = 26;
    localparam int HB_DO  = 8;
    localparam int HB_RDY = 9;

endpackage

// File: rtl/eep_host_lines.sv
// Holds the serial lines written by the host and turns clock rises into
// one-cycle bit strobes. Assumes all line bits live in byte lane HB_SCK/8.
module eep_host_lines
    import eep_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [REG_W/8-1:0] wr_be,
    output logic               bit_stb,
    output logic               bit_val,
    output logic               cs_n
);
    localparam int LANE = HB_SCK / 8;

    logic sck_q;
    logic lane_we;
    logic new_sck;
    logic new_csn;
    logic new_di;
    logic unused_host_bits;

    assign lane_we = wr_en && wr_be[LANE];
    assign new_sck = wr_data[HB_SCK];
    assign new_csn = wr_data[HB_CSN];
    assign new_di  = wr_data[HB_DI];
    assign unused_host_bits = ^{wr_data, wr_be};

    // Capture line levels on enabled writes and flag a selected clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            cs_n    <= 1'b1;
            bit_val <= 1'b0;
            bit_stb <= 1'b0;
        end else if (lane_we) begin
            bit_stb <= new_sck && !sck_q && !new_csn;
            sck_q   <= new_sck;
            cs_n    <= new_csn;
            bit_val <= new_di;
        end else begin
            bit_stb <= 1'b0;
        end
    end

endmodule

// File: rtl/eep_cmd_fsm.sv
// Decodes the serial bit stream into commands. It collects opcode, address
// and data bits, drives data-out during reads, and issues one-cycle requests
// to the array. Assumes bit_stb is only high while cs_n is low.
module eep_cmd_fsm
    import eep_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              cs_n,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_word,
    output logic              erase_req,
    output logic              lock_req,
    output logic              unlock_req,
    output logic              dout,
    output phase_t            phase
);
    localparam int MAX_A = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int MAX_N = (MAX_A > OP_LONG) ? MAX_A : OP_LONG;
    localparam int CNT_W = $clog2(MAX_N + 1);

    logic [OP_LONG-1:0] sh_q;
    logic [OP_LONG-1:0] sh_n;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cnt_inc;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;

    // Next shift values and read address with the incoming bit appended.
    always_comb begin
        sh_n    = {sh_q[OP_LONG-2:0], bit_val};
        cnt_inc = cnt_q + 1'b1;
        rd_addr = {addr_q[ADDR_W-2:0], bit_val};
    end

    assign wr_addr = addr_q;
    assign wr_word = data_q;

    // Command sequencing, advanced once per accepted serial bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_CMD;
            sh_q       <= '0;
            cnt_q      <= '0;
            addr_q     <= '0;
            data_q     <= '0;
            dout       <= 1'b0;
            wr_req     <= 1'b0;
            erase_req  <= 1'b0;
            lock_req   <= 1'b0;
            unlock_req <= 1'b0;
        end else begin
            wr_req     <= 1'b0;
            erase_req  <= 1'b0;
            lock_req   <= 1'b0;
            unlock_req <= 1'b0;
            if (cs_n) begin
                phase <= PH_CMD;
                sh_q  <= '0;
                cnt_q <= '0;
                dout  <= 1'b0;
            end else if (bit_stb) begin
                case (phase)
                    PH_CMD: begin
                        sh_q  <= sh_n;
                        cnt_q <= cnt_inc;
                        if (cnt_inc == CNT_W'(OP_SHORT) && sh_n[OP_SHORT-1:0] == PAT_READ) begin
                            phase <= PH_RADDR;
                            cnt_q <= '0;
                        end else if (cnt_inc == CNT_W'(OP_SHORT) && sh_n[OP_SHORT-1:0] == PAT_WRITE) begin
                            phase <= PH_WADDR;
                            cnt_q <= '0;
                        end else if (cnt_inc == CNT_W'(OP_LONG)) begin
                            phase      <= PH_HALT;
                            erase_req  <= (sh_n == PAT_ERASE);
                            lock_req   <= (sh_n == PAT_LOCK);
                            unlock_req <= (sh_n == PAT_UNLOCK);
                        end
                    end
                    PH_RADDR: begin
                        addr_q <= rd_addr;
                        cnt_q  <= cnt_inc;
                        if (cnt_inc == CNT_W'(ADDR_W)) begin
                            phase  <= PH_RDATA;
                            cnt_q  <= '0;
                            data_q <= rd_word;
                            dout   <= rd_word[DATA_W-1];
                        end
                    end
                    PH_RDATA: begin
                        if (cnt_inc == CNT_W'(DATA_W)) begin
                            phase <= PH_HALT;
                            dout  <= 1'b0;
                        end else begin
                            cnt_q  <= cnt_inc;
                            dout   <= data_q[DATA_W-2];
                            data_q <= {data_q[DATA_W-2:0], 1'b0};
                        end
                    end
                    PH_WADDR: begin
                        addr_q <= rd_addr;
                        cnt_q  <= cnt_inc;
                        if (cnt_inc == CNT_W'(ADDR_W)) begin
                            phase <= PH_WDATA;
                            cnt_q <= '0;
                        end
                    end
                    PH_WDATA: begin
                        data_q <= {data_q[DATA_W-2:0], bit_val};
                        cnt_q  <= cnt_inc;
                        if (cnt_inc == CNT_W'(DATA_W)) begin
                            phase  <= PH_HALT;
                            wr_req <= 1'b1;
                        end
                    end
                    default: phase <= PH_HALT;
                endcase
            end
        end
    end

endmodule

// File: rtl/eep_array.sv
// Word storage with a write-protect lock. Erase-all fills every word in one
// cycle. Assumes at most one request is high in any cycle.
module eep_array #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              erase_req,
    input  logic              lock_req,
    input  logic              unlock_req,
    output logic              locked
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_word = mem[rd_addr];

    // Lock state: set by reset or lock, cleared by unlock.
    always_ff @(posedge clk) begin
        if (!rst_n)          locked <= 1'b1;
        else if (lock_req)   locked <= 1'b1;
        else if (unlock_req) locked <= 1'b0;
    end

    // Storage update for unlocked erase-all and single-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n || (erase_req && !locked)) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_req && !locked) begin
            mem[wr_addr] <= wr_word;
        end
    end

endmodule

// File: rtl/eep_hostreg_top.sv
// Top of the bit-serial EEPROM model. It joins the host line register, the
// command decoder and the locked array, and assembles the host read word.
module eep_hostreg_top
    import eep_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [REG_W/8-1:0] wr_be,
    output logic [REG_W-1:0]   rd_data
);
    logic              bit_stb_w;
    logic              bit_val_w;
    logic              cs_n_w;
    logic [ADDR_W-1:0] rd_addr_w;
    logic [DATA_W-1:0] rd_word_w;
    logic              wr_req_w;
    logic [ADDR_W-1:0] wr_addr_w;
    logic [DATA_W-1:0] wr_word_w;
    logic              erase_req_w;
    logic              lock_req_w;
    logic              unlock_req_w;
    logic              locked_w;
    logic              dout_w;
    phase_t            phase_w;

    eep_host_lines #(.REG_W(REG_W)) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_be   (wr_be),
        .bit_stb (bit_stb_w),
        .bit_val (bit_val_w),
        .cs_n    (cs_n_w)
    );

    eep_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb_w),
        .bit_val    (bit_val_w),
        .cs_n       (cs_n_w),
        .rd_word    (rd_word_w),
        .rd_addr    (rd_addr_w),
        .wr_req     (wr_req_w),
        .wr_addr    (wr_addr_w),
        .wr_word    (wr_word_w),
        .erase_req  (erase_req_w),
        .lock_req   (lock_req_w),
        .unlock_req (unlock_req_w),
        .dout       (dout_w),
        .phase      (phase_w)
    );

    eep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (rd_addr_w),
        .rd_word    (rd_word_w),
        .wr_req     (wr_req_w),
        .wr_addr    (wr_addr_w),
        .wr_word    (wr_word_w),
        .erase_req  (erase_req_w),
        .lock_req   (lock_req_w),
        .unlock_req (unlock_req_w),
        .locked     (locked_w)
    );

    // Host read word: data-out and an always-set ready flag.
    always_comb begin
        rd_data         = '0;
        rd_data[HB_DO]  = dout_w;
        rd_data[HB_RDY] = 1'b1;
    end

endmodule

// File: rtl/eep_hostreg_checker.sv
// Protocol checks for the bit-serial EEPROM model, bound into the top.
// Assumes a synchronous active-low reset that is low from time zero.
module eep_hostreg_checker
    import eep_pkg::*;
#(
    parameter int REG_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [REG_W/8-1:0] wr_be,
    input logic [REG_W-1:0]   rd_data,
    input logic               bit_stb,
    input logic               cs_n,
    input logic               wr_req,
    input logic               lock_req,
    input logic               unlock_req,
    input logic               locked,
    input phase_t             phase
);
    localparam int LANE = HB_SCK / 8;

    AST_LANE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_be[LANE]) |=> (!bit_stb && $stable(cs_n)));          // R1
    AST_STB_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> !cs_n);                                                  // R3
    AST_DO_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[HB_DO] |-> (phase == PH_RDATA));                             // R4
    AST_WRITE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ($past(phase) == PH_WDATA));                              // R5
    AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_req |=> !locked);                                             // R7
    AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_req |=> locked);                                                // R7
    AST_LOCK_AT_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> locked);                                            // R8
    AST_UNLOCK_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(unlock_req));                                // R8
    AST_CS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (phase == PH_CMD && !rd_data[HB_DO]));                      // R9

endmodule

bind eep_hostreg_top eep_hostreg_checker #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_be      (wr_be),
    .rd_data    (rd_data),
    .bit_stb    (bit_stb_w),
    .cs_n       (cs_n_w),
    .wr_req     (wr_req_w),
    .lock_req   (lock_req_w),
    .unlock_req (unlock_req_w),
    .locked     (locked_w),
    .phase      (phase_w)
);

// File: tb/test_eep_hostreg_top.sv
`timescale 1ns/1ps
module test_eep_hostreg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] rd_data;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R11 reset";

    // behavioural reference state
    int m_mem [128];
    bit m_locked;
    int m_mode;   // 0 opcode, 1 read addr, 2 read out, 3 write addr, 4 write data, 5 ignore
    int m_n, m_acc, m_addr, m_word, m_pos;
    bit m_dout;
    bit m_sck, m_csn, m_di, m_stb;

    always #2 clk = ~clk;

    eep_hostreg_top i_eep_hostreg_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .wr_be(wr_be), .rd_data(rd_data)
    );

    task automatic model_reset();
        foreach (m_mem[i]) m_mem[i] = 255;
        m_locked = 1; m_mode = 0; m_n = 0; m_acc = 0; m_addr = 0;
        m_word = 0; m_pos = 0; m_dout = 0;
        m_sck = 0; m_csn = 1; m_di = 0; m_stb = 0;
    endtask

    task automatic model_bit(input bit b);
        case (m_mode)
            0: begin
                m_acc = m_acc * 2 + b; m_n++;
                if (m_n == 6 && m_acc == 24) begin m_mode = 1; m_n = 0; m_addr = 0; end
                else if (m_n == 6 && m_acc == 20) begin m_mode = 3; m_n = 0; m_addr = 0; end
                else if (m_n == 13) begin
                    if (m_acc == 'h900 && !m_locked) foreach (m_mem[i]) m_mem[i] = 255;
                    if (m_acc == 'h800) m_locked = 1;
                    if (m_acc == 'h980) m_locked = 0;
                    m_mode = 5;
                end
            end
            1: begin
                m_addr = m_addr * 2 + b; m_n++;
                if (m_n == 7) begin
                    m_word = m_mem[m_addr]; m_pos = 7;
                    m_dout = m_word[7]; m_mode = 2;
                end
            end
            2: begin
                m_pos--;
                if (m_pos < 0) begin m_dout = 0; m_mode = 5; end
                else m_dout = m_word[m_pos];
            end
            3: begin
                m_addr = m_addr * 2 + b; m_n++;
                if (m_n == 7) begin m_mode = 4; m_n = 0; m_word = 0; end
            end
            4: begin
                m_word = m_word * 2 + b; m_n++;
                if (m_n == 8) begin
                    if (!m_locked) m_mem[m_addr] = m_word;
                    m_mode = 5;
                end
            end
            default: ;
        endcase
    endtask

    task automatic model_edge(input bit we, input logic [31:0] d, input logic [3:0] be);
        if (!rst_n) begin
            model_reset();
            return;
        end
        if (m_csn) begin m_mode = 0; m_n = 0; m_acc = 0; m_dout = 0; end
        else if (m_stb) model_bit(m_di);
        if (we && be[3]) begin
            m_stb = d[26] && !m_sck && !d[25];
            m_sck = d[26]; m_csn = d[25]; m_di = d[24];
        end else m_stb = 0;
    endtask

    task automatic tick(input bit we, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] exp;
        wr_en = we; wr_data = d; wr_be = be;
        @(posedge clk);
        model_edge(we, d, be);
        @(negedge clk);
        exp = 32'h0000_0200 | (32'(m_dout) << 8);
        n_cmp++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected %h", cur_req, rd_data, exp);
        end
    endtask

    function automatic logic [31:0] lines(input bit cs, input bit sck, input bit di);
        return {5'b0, sck, ~cs, di, 24'h0};
    endfunction

    task automatic hw(input bit cs, input bit sck, input bit di);
        tick(1, lines(cs, sck, di), 4'b1000);
        tick(0, 32'h0, 4'h0);
    endtask

    task automatic sbit(input bit b);
        hw(1, 0, b);
        hw(1, 1, b);
    endtask

    task automatic send(input int val, input int len);
        for (int i = len - 1; i >= 0; i--) sbit(val[i]);
    endtask

    task automatic cs_off();
        hw(0, 0, 0);
    endtask

    task automatic do_read(input int a);
        send(24, 6); send(a, 7); send(0, 9); cs_off();
    endtask

    task automatic do_write(input int a, input int v);
        send(20, 6); send(a, 7); send(v, 8); cs_off();
    endtask

    task automatic do_long(input int v);
        send(v, 13); cs_off();
    endtask

    initial begin
        model_reset();
        cur_req = "R11 reset state";
        repeat (3) tick(0, 32'h0, 4'h0);
        rst_n = 1'b1;
        repeat (2) tick(0, 32'h0, 4'h0);
        do_read(5); do_read(127);

        cur_req = "R8 locked write ignored";
        do_write(5, 'h3C); do_read(5);

        cur_req = "R7 unlock";
        do_long('h980);
        cur_req = "R5 write";
        do_write(5, 'h3C); do_write(127, 'hA5); do_write(0, 'h01); do_write(64, 'h80);
        cur_req = "R4 read back";
        do_read(5); do_read(127); do_read(0); do_read(64);

        cur_req = "R1 lane and bit ignore";
        send(24, 6); send(5, 7);
        tick(1, lines(1, 1, 1), 4'b0111); tick(0, 0, 0);
        tick(1, lines(1, 0, 0) | 32'hF8FF_FFFF, 4'b1000); tick(0, 0, 0);
        tick(0, lines(1, 1, 0), 4'b1000); tick(0, 0, 0);
        cur_req = "R2 data-out bit";
        send(0, 9); cs_off();

        cur_req = "R3 held clock adds no bit";
        send(24, 6); send(127, 6);
        hw(1, 1, 1); hw(1, 1, 0);
        sbit(1); send(0, 9); cs_off();

        cur_req = "R9 cs drop mid command";
        send(24, 3); cs_off(); do_read(127);
        send(24, 6); send(127, 7); sbit(0); cs_off(); sbit(1); cs_off();
        send(20, 6); send(9, 7); send(3, 4); cs_off(); do_read(9);

        cur_req = "R10 unknown code";
        send('h1234, 13); send(24, 6); send(5, 7); send(0, 9); cs_off();

        cur_req = "R6 erase all";
        do_long('h900); do_read(5); do_read(127);
        cur_req = "R7 lock";
        do_write(9, 'h55); do_long('h800);
        cur_req = "R8 locked erase and write";
        do_long('h900); do_write(9, 'hAA); do_read(9);
        cur_req = "R7 relock cycle";
        do_long('h980); do_write(9, 'h96); do_read(9);

        cur_req = "R11 reset again";
        rst_n = 1'b0; repeat (2) tick(0, 0, 0);
        rst_n = 1'b1; tick(0, 0, 0);
        do_read(9); do_write(9, 'h00); do_read(9);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: finished=0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule